// File: doc/BRIEF.md
# Add-Compare-Branch Execution Unit

This unit is the execute stage of a fused loop-control operation. In one issue slot it adds a small signed immediate, or a second register, to a source register and produces the value that goes back to that register. It then tests a selected condition on the sum and produces three things: a branch-taken flag, a branch target, and a flag that squashes the delay-slot instruction that follows.

A compare-only mode tests the same conditions but produces no writeback. An increment-and-compare mode adds one to a counter and compares the new count with a second register rather than with zero. This lets a count-up loop close without negating its bound.

All results are registered once and qualified by a valid input, so they appear on the cycle after issue. Fetch, the register file and hazard handling live elsewhere.

Top module: `acb_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_wb_en`, `out_taken`, `out_nullify`, `out_wb_data` and `out_target` are all zero.
- R2: With `in_mode`=0 (add immediate), one cycle after a valid issue `out_wb_en`=1 and `out_wb_data` = `in_src` + the 5-bit `in_imm` sign-extended to 64 bits.
- R3: With `in_mode`=1 (add register), one cycle after a valid issue `out_wb_en`=1 and `out_wb_data` = `in_src` + `in_opnd`, modulo 2^64.
- R4: With `in_mode`=2 (compare only), the condition is evaluated on `in_src` + sign-extended `in_imm`, and `out_wb_en` is 0 one cycle after issue.
- R5: With `in_mode`=3 (increment-compare), `out_wb_data` = `in_src`+1 with `out_wb_en`=1. The comparison conditions test that count against `in_opnd` as signed values instead of against zero.
- R6: `in_cond` selects the test. Codes 0 to 5 are: 0 never, 1 equal, 2 signed less than, 3 less or equal, 4 greater than, 5 greater or equal. In modes 0 to 2 these compare the sum with zero.
- R7: `in_cond`=6 takes the branch exactly when the add overflows as a signed operation: both operands have the same sign and the sum has the other sign.
- R8: `in_cond`=7 takes the branch exactly when the unsigned 64-bit add carries out of bit 63.
- R9: One cycle after a valid issue, `out_target` = `in_pc` + 8 + (`in_disp` sign-extended and shifted left by 2). `in_disp` is 11 bits, giving a reach of -4096 to +4092 bytes around `in_pc`+8.
- R10: One cycle after a valid issue, `out_nullify` is 1 exactly when `in_nullify` was 1 and the branch was not taken. It is never 1 together with `out_taken`.
- R11: A cycle in which `in_valid` is 0 is followed by a cycle in which `out_valid`, `out_wb_en`, `out_taken` and `out_nullify` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is issued this cycle |
| in_mode | input | 2 | 0 add imm, 1 add reg, 2 compare only, 3 increment-compare |
| in_cond | input | 3 | Branch condition code (R6 to R8) |
| in_nullify | input | 1 | Squash the delay slot when not taken |
| in_imm | input | 5 | Signed immediate addend |
| in_disp | input | 11 | Signed word displacement |
| in_pc | input | 64 | Address of the branch |
| in_src | input | 64 | Source and destination register value |
| in_opnd | input | 64 | Second register: addend or compare bound |
| out_valid | output | 1 | Results below belong to an issued operation |
| out_wb_en | output | 1 | Write `out_wb_data` back to the source register |
| out_wb_data | output | 64 | Sum to write back |
| out_taken | output | 1 | Branch taken |
| out_target | output | 64 | Branch target address |
| out_nullify | output | 1 | Squash the delay-slot instruction |

## Verification
The condition logic keeps no state beyond the one output register stage. A wrong mux select or a wrong sign or carry bit therefore shows on `out_taken` or `out_nullify` in the very next cycle after the offending issue. A stale or unqualified output register shows as `out_valid`, `out_taken` or `out_nullify` staying high in a cycle after an idle input. The boundary values that matter are the sign and carry edges: a sum of exactly zero, minus one, the largest positive value plus one, and all-ones plus one. The displacement extremes matter for the target.

// File: rtl/acb_unit.sv
module acb_unit #(
  parameter int XLEN   = 64,
  parameter int PC_W   = 64,
  parameter int IMM_W  = 5,
  parameter int DISP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_mode,
  input  logic [2:0]        in_cond,
  input  logic              in_nullify,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [XLEN-1:0]   in_src,
  input  logic [XLEN-1:0]   in_opnd,
  output logic              out_valid,
  output logic              out_wb_en,
  output logic [XLEN-1:0]   out_wb_data,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_target,
  output logic              out_nullify
);
  localparam logic [1:0] M_ADDI = 2'd0;
  localparam logic [1:0] M_ADDR = 2'd1;
  localparam logic [1:0] M_CMPI = 2'd2;
  localparam logic [1:0] M_INCC = 2'd3;

  localparam logic [2:0] C_NEVER = 3'd0;
  localparam logic [2:0] C_EQ    = 3'd1;
  localparam logic [2:0] C_LT    = 3'd2;
  localparam logic [2:0] C_LE    = 3'd3;
  localparam logic [2:0] C_GT    = 3'd4;
  localparam logic [2:0] C_GE    = 3'd5;
  localparam logic [2:0] C_OV    = 3'd6;
  localparam logic [2:0] C_CY    = 3'd7;

  localparam int SLOT_BYTES = 8;
  localparam int DISP_PAD   = PC_W - DISP_W - 2;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] addend;
  logic [XLEN:0]   sum_ext;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] rhs;
  logic            carry, ovf, is_eq, is_lt, hit;
  logic [PC_W-1:0] disp_off, target;

  assign imm_ext = {{(XLEN-IMM_W){in_imm[IMM_W-1]}}, in_imm};

  always_comb begin
    case (in_mode)
      M_ADDR:  addend = in_opnd;
      M_INCC:  addend = XLEN'(1);
      default: addend = imm_ext;
    endcase
  end

  assign sum_ext = {1'b0, in_src} + {1'b0, addend};
  assign sum     = sum_ext[XLEN-1:0];
  assign carry   = sum_ext[XLEN];
  assign ovf     = (in_src[XLEN-1] == addend[XLEN-1]) && (sum[XLEN-1] != in_src[XLEN-1]);

  assign rhs   = (in_mode == M_INCC) ? in_opnd : '0;
  assign is_eq = (sum == rhs);
  assign is_lt = $signed(sum) < $signed(rhs);

  always_comb begin
    case (in_cond)
      C_EQ:    hit = is_eq;
      C_LT:    hit = is_lt;
      C_LE:    hit = is_lt | is_eq;
      C_GT:    hit = ~(is_lt | is_eq);
      C_GE:    hit = ~is_lt;
      C_OV:    hit = ovf;
      C_CY:    hit = carry;
      C_NEVER: hit = 1'b0;
      default: hit = 1'b0;
    endcase
  end

  assign disp_off = {{DISP_PAD{in_disp[DISP_W-1]}}, in_disp, 2'b00};
  assign target   = in_pc + PC_W'(SLOT_BYTES) + disp_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wb_en   <= 1'b0;
      out_taken   <= 1'b0;
      out_nullify <= 1'b0;
      out_wb_data <= '0;
      out_target  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_wb_en   <= in_valid && (in_mode != M_CMPI);
      out_taken   <= in_valid && hit;
      out_nullify <= in_valid && in_nullify && !hit;
      if (in_valid) begin
        out_wb_data <= sum;
        out_target  <= target;
      end
    end
  end
endmodule

// File: rtl/acb_unit_chk.sv
module acb_unit_chk #(
  parameter int XLEN   = 64,
  parameter int PC_W   = 64,
  parameter int IMM_W  = 5,
  parameter int DISP_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_mode,
  input logic [2:0]        in_cond,
  input logic              in_nullify,
  input logic [IMM_W-1:0]  in_imm,
  input logic [DISP_W-1:0] in_disp,
  input logic [PC_W-1:0]   in_pc,
  input logic [XLEN-1:0]   in_src,
  input logic [XLEN-1:0]   in_opnd,
  input logic              out_valid,
  input logic              out_wb_en,
  input logic [XLEN-1:0]   out_wb_data,
  input logic              out_taken,
  input logic [PC_W-1:0]   out_target,
  input logic              out_nullify
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_wb_en && !out_taken && !out_nullify);

  p_null_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_nullify && out_taken));

  p_null_when_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_nullify |=> out_nullify == !out_taken);

  p_cmp_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'd2 |=> out_valid && !out_wb_en);

  p_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cond == 3'd0 |=> !out_taken);

  p_inc_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'd3 |=> out_wb_en && out_wb_data == $past(in_src) + XLEN'(1));

  p_addr_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'd1 |=> out_wb_en && out_wb_data == $past(in_src) + $past(in_opnd));

  p_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_disp == '0 |=> out_target == $past(in_pc) + PC_W'(8));

  p_hold_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_valid |=> $stable(out_target) && $stable(out_wb_data));
endmodule

bind acb_unit acb_unit_chk #(.XLEN(XLEN), .PC_W(PC_W), .IMM_W(IMM_W), .DISP_W(DISP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_cond(in_cond),
  .in_nullify(in_nullify), .in_imm(in_imm), .in_disp(in_disp), .in_pc(in_pc),
  .in_src(in_src), .in_opnd(in_opnd), .out_valid(out_valid), .out_wb_en(out_wb_en),
  .out_wb_data(out_wb_data), .out_taken(out_taken), .out_target(out_target),
  .out_nullify(out_nullify)
);

// File: tb/acb_unit_tb.sv
module acb_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_mode = '0;
  logic [2:0]  in_cond = '0;
  logic        in_nullify = 1'b0;
  logic [4:0]  in_imm = '0;
  logic [10:0] in_disp = '0;
  logic [63:0] in_pc = '0;
  logic [63:0] in_src = '0;
  logic [63:0] in_opnd = '0;
  logic        out_valid, out_wb_en, out_taken, out_nullify;
  logic [63:0] out_wb_data, out_target;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  acb_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_cond(in_cond),
    .in_nullify(in_nullify), .in_imm(in_imm), .in_disp(in_disp), .in_pc(in_pc),
    .in_src(in_src), .in_opnd(in_opnd), .out_valid(out_valid), .out_wb_en(out_wb_en),
    .out_wb_data(out_wb_data), .out_taken(out_taken), .out_target(out_target),
    .out_nullify(out_nullify)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] mode, input logic [2:0] cond, input logic nul,
                       input logic [63:0] src, input logic [63:0] opnd, input logic [4:0] imm,
                       input logic [10:0] disp, input logic [63:0] pc);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_cond = cond; in_nullify = nul;
    in_src = src; in_opnd = opnd; in_imm = imm; in_disp = disp; in_pc = pc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 wb_en", {63'd0, out_wb_en}, 64'd0);
    chk("R1 taken", {63'd0, out_taken}, 64'd0);
    chk("R1 nullify", {63'd0, out_nullify}, 64'd0);
    chk("R1 wb_data", out_wb_data, 64'd0);
    chk("R1 target", out_target, 64'd0);
  endtask

  task automatic t_addi();
    issue(2'd0, 3'd5, 1'b1, 64'd10, 64'd0, 5'h1F, 11'h7FE, 64'h1000);
    chk("R2 wb_data 10-1", out_wb_data, 64'd9);
    chk("R2 wb_en", {63'd0, out_wb_en}, 64'd1);
    chk("R6 ge taken", {63'd0, out_taken}, 64'd1);
    chk("R9 target back", out_target, 64'h1000);
    chk("R10 no nullify when taken", {63'd0, out_nullify}, 64'd0);
    issue(2'd0, 3'd5, 1'b1, 64'd0, 64'd0, 5'h1F, 11'h3FF, 64'h2000);
    chk("R2 wb_data 0-1", out_wb_data, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 ge not taken", {63'd0, out_taken}, 64'd0);
    chk("R10 nullify on fall through", {63'd0, out_nullify}, 64'd1);
    chk("R9 target fwd max", out_target, 64'h3004);
  endtask

  task automatic t_addr();
    issue(2'd1, 3'd1, 1'b1, 64'd5, 64'hFFFF_FFFF_FFFF_FFFB, 5'd0, 11'h400, 64'h10000);
    chk("R3 wb_data", out_wb_data, 64'd0);
    chk("R6 eq taken", {63'd0, out_taken}, 64'd1);
    chk("R10 taken keeps slot", {63'd0, out_nullify}, 64'd0);
    chk("R9 target back max", out_target, 64'h10000 + 64'd8 - 64'd4096);
  endtask

  task automatic t_overflow();
    issue(2'd1, 3'd6, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 11'd0, 64'd0);
    chk("R7 ovf taken", {63'd0, out_taken}, 64'd1);
    chk("R3 wrap sum", out_wb_data, 64'h8000_0000_0000_0000);
    issue(2'd1, 3'd6, 1'b1, 64'd1, 64'd1, 5'd0, 11'd0, 64'd0);
    chk("R7 no ovf", {63'd0, out_taken}, 64'd0);
    chk("R10 nullify no ovf", {63'd0, out_nullify}, 64'd1);
    issue(2'd1, 3'd6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 11'd0, 64'd0);
    chk("R7 mixed signs no ovf", {63'd0, out_taken}, 64'd0);
  endtask

  task automatic t_carry();
    issue(2'd1, 3'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 11'd0, 64'd0);
    chk("R8 carry taken", {63'd0, out_taken}, 64'd1);
    issue(2'd1, 3'd7, 1'b0, 64'd5, 64'd3, 5'd0, 11'd0, 64'd0);
    chk("R8 no carry", {63'd0, out_taken}, 64'd0);
    issue(2'd1, 3'd7, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 11'd0, 64'd0);
    chk("R8 ovf is not carry", {63'd0, out_taken}, 64'd0);
  endtask

  task automatic t_cmp_only();
    issue(2'd2, 3'd1, 1'b0, 64'd3, 64'd0, 5'h1D, 11'd0, 64'd0);
    chk("R4 cmp eq taken", {63'd0, out_taken}, 64'd1);
    chk("R4 no writeback", {63'd0, out_wb_en}, 64'd0);
    chk("R4 valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_inc_cmp();
    issue(2'd3, 3'd2, 1'b1, 64'd4, 64'd5, 5'd0, 11'd0, 64'd0);
    chk("R5 count", out_wb_data, 64'd5);
    chk("R5 wb_en", {63'd0, out_wb_en}, 64'd1);
    chk("R5 lt at bound not taken", {63'd0, out_taken}, 64'd0);
    chk("R10 inc fall through", {63'd0, out_nullify}, 64'd1);
    issue(2'd3, 3'd3, 1'b0, 64'd4, 64'd5, 5'd0, 11'd0, 64'd0);
    chk("R5 le at bound taken", {63'd0, out_taken}, 64'd1);
    issue(2'd3, 3'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 5'd0, 11'd0, 64'd0);
    chk("R5 signed lt taken", {63'd0, out_taken}, 64'd1);
    issue(2'd3, 3'd4, 1'b0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 11'd0, 64'd0);
    chk("R5 gt vs negative taken", {63'd0, out_taken}, 64'd1);
  endtask

  task automatic t_conds();
    issue(2'd0, 3'd4, 1'b0, 64'd1, 64'd0, 5'h1F, 11'd0, 64'd0);
    chk("R6 gt at zero", {63'd0, out_taken}, 64'd0);
    issue(2'd0, 3'd3, 1'b0, 64'd1, 64'd0, 5'h1F, 11'd0, 64'd0);
    chk("R6 le at zero", {63'd0, out_taken}, 64'd1);
    issue(2'd0, 3'd2, 1'b0, 64'd1, 64'd0, 5'h1F, 11'd0, 64'd0);
    chk("R6 lt at zero", {63'd0, out_taken}, 64'd0);
    issue(2'd0, 3'd0, 1'b0, 64'd1, 64'd0, 5'h1F, 11'd0, 64'd0);
    chk("R6 never", {63'd0, out_taken}, 64'd0);
    issue(2'd0, 3'd4, 1'b0, 64'd0, 64'd0, 5'h0F, 11'd0, 64'd0);
    chk("R6 gt positive", {63'd0, out_taken}, 64'd1);
    chk("R2 max imm", out_wb_data, 64'd15);
  endtask

  task automatic t_idle();
    issue(2'd1, 3'd1, 1'b0, 64'd0, 64'd0, 5'd0, 11'd0, 64'd0);
    chk("R11 prior taken", {63'd0, out_taken}, 64'd1);
    @(negedge clk);
    chk("R11 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R11 idle taken", {63'd0, out_taken}, 64'd0);
    chk("R11 idle wb_en", {63'd0, out_wb_en}, 64'd0);
    chk("R11 idle nullify", {63'd0, out_nullify}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addi();
    t_addr();
    t_overflow();
    t_carry();
    t_cmp_only();
    t_inc_cmp();
    t_conds();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule